// File: doc/BRIEF.md
# Double-Buffered Transmit Frame Queue

This block sits between software and the transmit engine of an Ethernet MAC. Software first writes the buffer address of a frame, then a control word that carries the byte count and a flag that turns off CRC insertion. The block keeps two frame slots. The active slot holds the frame being handed to, or sent by, the engine. The waiting slot holds one frame queued behind it. The block drives the engine through a one-cycle start pulse and receives a done pulse in return.

Alongside the queue, the block keeps the transmit status flags. The queue-free and idle flags follow the slot state. The overrun, completion, underrun, collision and retry-limit flags are sticky and are cleared by writing a one. Each frame is classified before it is offered to the engine: whether CRC is appended, whether it is oversize, and whether it is short. The engine holds a start until the fetch logic reports at least two 32-bit words ready. When the engine reports a memory underrun, the block tells it to corrupt the CRC of the frame in flight.

Top module: `txframe_queue`

## Requirements
- R1: After reset, `tx_status` reads 7'b0000011: queue-free (bit 0) and idle (bit 1) are set, every sticky flag is clear, and `eng_start` is low.
- R2: A control write with a nonzero length field (bits 10:0) while queue-free is set accepts a frame at the most recently written address. A zero length is ignored: no start is issued, and idle and queue-free keep their values.
- R3: `eng_start` is a single-cycle pulse. It is raised only while an unstarted active frame exists and `fifo_lvl` is at least 2, and it carries the address and length of that frame.
- R4: A frame accepted while another is in progress waits in the second slot. Queue-free (bit 0) reads 0 exactly while both slots are full.
- R5: An address or control write while queue-free is clear sets the overrun flag (bit 3). It does not change the staged address or the waiting frame.
- R6: On a done pulse for a started frame, the completion flag (bit 2) is set. A waiting frame becomes the active frame at that same clock edge, and queue-free reads 1 again.
- R7: Idle (bit 1) is cleared by an accepted length write. It is set by a done pulse when no frame is waiting.
- R8: `rd_len` and `rd_nocrc` show the length and no-CRC flag of the active frame. They stay unchanged while that frame is sent, even when another frame is queued.
- R9: The no-CRC flag is control bit 15. CRC is appended when that flag is 0. A frame is oversize when its length exceeds 1514 (1518 with no-CRC). A frame is short when no-CRC is set and the length is below 64.
- R10: An underrun pulse during a started frame sets the underrun flag (bit 4) and raises `eng_bad_crc` until that frame's done pulse.
- R11: Writing ones through `clr_mask` clears the completion, overrun, underrun, collision and retry-limit flags. Mask bits 0 and 1 have no effect. A flag event in the same cycle wins over its clear.
- R12: A collision pulse sets bit 5 and a retry-limit pulse sets bit 6. Both flags stay set until cleared.
- R13: A done pulse when no started frame exists is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_wr | input | 1 | Address write strobe |
| addr_val | input | 32 | Buffer address |
| ctl_wr | input | 1 | Control write strobe |
| ctl_val | input | 16 | Length in bits 10:0, no-CRC flag in bit 15 |
| clr_wr | input | 1 | Status clear strobe |
| clr_mask | input | 7 | Write-one-to-clear mask, same positions as tx_status |
| fifo_lvl | input | 4 | 32-bit words ready in the transmit FIFO |
| eng_done | input | 1 | Engine finished the active frame |
| eng_col | input | 1 | Collision event |
| eng_rlim | input | 1 | Retry limit exceeded event |
| eng_under | input | 1 | Memory underrun event |
| eng_start | output | 1 | Start pulse to the engine |
| eng_addr | output | 32 | Active frame address |
| eng_len | output | 11 | Active frame length |
| eng_append_crc | output | 1 | Engine appends CRC |
| eng_oversize | output | 1 | Active frame is oversize |
| eng_short | output | 1 | Active frame is short |
| eng_bad_crc | output | 1 | Force bad CRC on the frame in flight |
| tx_status | output | 7 | {rle, col, und, ovr, comp, idle, queue-free} |
| rd_len | output | 11 | Length readback of the active frame |
| rd_nocrc | output | 1 | No-CRC readback of the active frame |

## Verification
The hardest state to reach is a full queue, with one frame started in the engine and a second one waiting. Only in that state can overrun rejection and promotion on done be observed. The bench holds the first frame in flight by withholding the done pulse. It then queues a second frame with no-CRC set and issues one rejected address write and one rejected control write. Finally it releases done and checks that the promoted frame carries the second frame's address and length, not the rejected ones.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int STAT_W  = 7;
  localparam int ST_FREE = 0;
  localparam int ST_IDLE = 1;
  localparam int ST_COMP = 2;
  localparam int ST_OVR  = 3;
  localparam int ST_UND  = 4;
  localparam int ST_COL  = 5;
  localparam int ST_RLE  = 6;
  // bits that software clears by writing one
  localparam logic [STAT_W-1:0] STICKY_MASK = 7'b1111100;
  typedef logic [STAT_W-1:0] txq_stat_t;
endpackage

// File: rtl/txq_frame_class.sv
module txq_frame_class #(
  parameter int LW        = 11,
  parameter int MAX_PAY   = 1514,
  parameter int CRC_BYTES = 4,
  parameter int MIN_FRAME = 64
) (
  input  logic [LW-1:0] len,
  input  logic          nocrc,
  output logic          append_crc,
  output logic          oversize,
  output logic          short_frm
);
  localparam int MAX_RAW = MAX_PAY + CRC_BYTES;
  int len_i;

  always_comb begin
    len_i      = int'(len);
    append_crc = ~nocrc;
    oversize   = nocrc ? (len_i > MAX_RAW) : (len_i > MAX_PAY);
    short_frm  = nocrc & (len_i < MIN_FRAME);
  end
endmodule

// File: rtl/txq_slots.sv
module txq_slots #(
  parameter int AW = 32,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_wr,
  input  logic [AW-1:0] addr_val,
  input  logic          ctl_wr,
  input  logic [LW-1:0] ctl_len,
  input  logic          ctl_nocrc,
  input  logic          fifo_ok,
  input  logic          eng_done,
  output logic          start,
  output logic          done_ok,
  output logic          load_ok,
  output logic          ovr_evt,
  output logic          q_full,
  output logic          q_v,
  output logic          act_run,
  output logic [AW-1:0] act_addr,
  output logic [LW-1:0] act_len,
  output logic          act_nocrc
);
  logic          act_v, act_v_n, run_n, q_v_n;
  logic [AW-1:0] stage_q, q_addr;
  logic [LW-1:0] q_len;
  logic          q_nocrc;
  logic          stage_en, act_ld, act_from_q, q_ld;
  logic          free;

  // handshake and acceptance decode
  always_comb begin
    free       = ~(act_v & q_v);
    q_full     = ~free;
    ovr_evt    = (addr_wr | ctl_wr) & ~free;
    stage_en   = addr_wr & free;
    load_ok    = ctl_wr & free & (ctl_len != '0);
    done_ok    = eng_done & act_run;
    start      = act_v & ~act_run & fifo_ok;
    act_from_q = done_ok & q_v;
    act_ld     = act_from_q | (load_ok & (done_ok | ~act_v));
    q_ld       = load_ok & act_v & ~done_ok;
  end

  // next state of slot occupancy
  always_comb begin
    act_v_n = act_v;
    run_n   = act_run;
    q_v_n   = q_v;
    if (act_ld) begin
      act_v_n = 1'b1;
      run_n   = 1'b0;
    end else if (done_ok) begin
      act_v_n = 1'b0;
      run_n   = 1'b0;
    end else if (start) begin
      run_n   = 1'b1;
    end
    if (q_ld)            q_v_n = 1'b1;
    else if (act_from_q) q_v_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_v   <= 1'b0;
      act_run <= 1'b0;
      q_v     <= 1'b0;
    end else begin
      act_v   <= act_v_n;
      act_run <= run_n;
      q_v     <= q_v_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (stage_en) begin
      stage_q <= addr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_addr  <= '0;
      act_len   <= '0;
      act_nocrc <= 1'b0;
    end else if (act_ld) begin
      if (act_from_q) begin
        act_addr  <= q_addr;
        act_len   <= q_len;
        act_nocrc <= q_nocrc;
      end else begin
        act_addr  <= stage_q;
        act_len   <= ctl_len;
        act_nocrc <= ctl_nocrc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_addr  <= '0;
      q_len   <= '0;
      q_nocrc <= 1'b0;
    end else if (q_ld) begin
      q_addr  <= stage_q;
      q_len   <= ctl_len;
      q_nocrc <= ctl_nocrc;
    end
  end

  assert_promote_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok && q_v) |=> (act_v && !q_v && act_addr == $past(q_addr) && act_len == $past(q_len)));

  assert_one_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  assert_len_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_run && !eng_done) |=> ($stable(act_len) && $stable(act_nocrc)));

  assert_reject_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ($stable(q_addr) && $stable(q_len) && $stable(stage_q)));

  assert_stray_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !act_v) |=> (!act_v && !q_v));
endmodule

// File: rtl/txq_status.sv
module txq_status
  import txq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ovr_evt,
  input  logic      done_ok,
  input  logic      load_ok,
  input  logic      q_v,
  input  logic      act_run,
  input  logic      eng_col,
  input  logic      eng_rlim,
  input  logic      eng_under,
  input  logic      clr_wr,
  input  txq_stat_t clr_mask,
  output txq_stat_t sticky,
  output logic      idle,
  output logic      bad_crc
);
  txq_stat_t set_vec, clr_vec;
  logic      idle_n, bad_n;

  always_comb begin
    set_vec          = '0;
    set_vec[ST_COMP] = done_ok;
    set_vec[ST_OVR]  = ovr_evt;
    set_vec[ST_UND]  = eng_under & act_run;
    set_vec[ST_COL]  = eng_col;
    set_vec[ST_RLE]  = eng_rlim;
    clr_vec          = clr_wr ? clr_mask : '0;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_flag
    if (STICKY_MASK[i]) begin : g_sticky
      logic flag_n;
      always_comb flag_n = set_vec[i] | (sticky[i] & ~clr_vec[i]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sticky[i] <= 1'b0;
        else        sticky[i] <= flag_n;
      end
    end else begin : g_none
      assign sticky[i] = 1'b0;
    end
  end

  always_comb begin
    idle_n = idle;
    if (load_ok)               idle_n = 1'b0;
    else if (done_ok && !q_v)  idle_n = 1'b1;
    bad_n = bad_crc;
    if (done_ok)                     bad_n = 1'b0;
    else if (eng_under && act_run)   bad_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle    <= 1'b1;
      bad_crc <= 1'b0;
    end else begin
      idle    <= idle_n;
      bad_crc <= bad_n;
    end
  end

  assert_ovr_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> sticky[ST_OVR]);

  assert_idle_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> !idle);

  assert_badcrc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_crc && !done_ok) |=> bad_crc);

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_col |=> sticky[ST_COL]);
endmodule

// File: rtl/txframe_queue.sv
module txframe_queue
  import txq_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LW        = 11,
  parameter int CTL_W     = 16,
  parameter int NOCRC_BIT = 15,
  parameter int FLW       = 4,
  parameter int MIN_WORDS = 2,
  parameter int MAX_PAY   = 1514,
  parameter int CRC_BYTES = 4,
  parameter int MIN_FRAME = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic [AW-1:0]     addr_val,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_val,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_mask,
  input  logic [FLW-1:0]    fifo_lvl,
  input  logic              eng_done,
  input  logic              eng_col,
  input  logic              eng_rlim,
  input  logic              eng_under,
  output logic              eng_start,
  output logic [AW-1:0]     eng_addr,
  output logic [LW-1:0]     eng_len,
  output logic              eng_append_crc,
  output logic              eng_oversize,
  output logic              eng_short,
  output logic              eng_bad_crc,
  output logic [STAT_W-1:0] tx_status,
  output logic [LW-1:0]     rd_len,
  output logic              rd_nocrc
);
  logic          fifo_ok, done_ok, load_ok, ovr_evt, q_full, q_v, act_run;
  logic [AW-1:0] act_addr;
  logic [LW-1:0] act_len;
  logic          act_nocrc, idle;
  txq_stat_t     sticky;
  logic          ctl_unused;

  assign fifo_ok    = fifo_lvl >= FLW'(MIN_WORDS);
  assign ctl_unused = ^ctl_val[NOCRC_BIT-1:LW];

  txq_slots #(.AW(AW), .LW(LW)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_wr   (addr_wr),
    .addr_val  (addr_val),
    .ctl_wr    (ctl_wr),
    .ctl_len   (ctl_val[LW-1:0]),
    .ctl_nocrc (ctl_val[NOCRC_BIT]),
    .fifo_ok   (fifo_ok),
    .eng_done  (eng_done),
    .start     (eng_start),
    .done_ok   (done_ok),
    .load_ok   (load_ok),
    .ovr_evt   (ovr_evt),
    .q_full    (q_full),
    .q_v       (q_v),
    .act_run   (act_run),
    .act_addr  (act_addr),
    .act_len   (act_len),
    .act_nocrc (act_nocrc)
  );

  txq_frame_class #(
    .LW(LW), .MAX_PAY(MAX_PAY), .CRC_BYTES(CRC_BYTES), .MIN_FRAME(MIN_FRAME)
  ) u_class (
    .len        (act_len),
    .nocrc      (act_nocrc),
    .append_crc (eng_append_crc),
    .oversize   (eng_oversize),
    .short_frm  (eng_short)
  );

  txq_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovr_evt   (ovr_evt),
    .done_ok   (done_ok),
    .load_ok   (load_ok),
    .q_v       (q_v),
    .act_run   (act_run),
    .eng_col   (eng_col),
    .eng_rlim  (eng_rlim),
    .eng_under (eng_under),
    .clr_wr    (clr_wr),
    .clr_mask  (clr_mask),
    .sticky    (sticky),
    .idle      (idle),
    .bad_crc   (eng_bad_crc)
  );

  always_comb begin
    tx_status          = sticky;
    tx_status[ST_FREE] = ~q_full;
    tx_status[ST_IDLE] = idle;
    eng_addr           = act_addr;
    eng_len            = act_len;
    rd_len             = act_len;
    rd_nocrc           = act_nocrc;
  end

  assert_full_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !eng_done) |=> q_full);

  assert_start_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_lvl < FLW'(MIN_WORDS)) |-> !eng_start);
endmodule

// File: tb/tb_txframe_queue.sv
`timescale 1ns/1ps
module tb_txframe_queue;
  localparam int AW = 32;
  localparam int LW = 11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          addr_wr, ctl_wr, clr_wr;
  logic [AW-1:0] addr_val;
  logic [15:0]   ctl_val;
  logic [6:0]    clr_mask;
  logic [3:0]    fifo_lvl;
  logic          eng_done, eng_col, eng_rlim, eng_under;
  logic          eng_start, eng_append_crc, eng_oversize, eng_short, eng_bad_crc;
  logic [AW-1:0] eng_addr;
  logic [LW-1:0] eng_len, rd_len;
  logic [6:0]    tx_status;
  logic          rd_nocrc;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  txframe_queue dut (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_val(addr_val),
    .ctl_wr(ctl_wr), .ctl_val(ctl_val), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .fifo_lvl(fifo_lvl), .eng_done(eng_done), .eng_col(eng_col),
    .eng_rlim(eng_rlim), .eng_under(eng_under), .eng_start(eng_start),
    .eng_addr(eng_addr), .eng_len(eng_len), .eng_append_crc(eng_append_crc),
    .eng_oversize(eng_oversize), .eng_short(eng_short),
    .eng_bad_crc(eng_bad_crc), .tx_status(tx_status), .rd_len(rd_len),
    .rd_nocrc(rd_nocrc)
  );

  // {control word, append_crc, oversize, short}
  localparam logic [18:0] VEC [0:8] = '{
    {16'd100,                3'b100},
    {16'd1514,               3'b100},
    {16'd1515,               3'b110},
    {16'h8000 | 16'd1518,    3'b000},
    {16'h8000 | 16'd1519,    3'b010},
    {16'h8000 | 16'd63,      3'b001},
    {16'h8000 | 16'd64,      3'b000},
    {16'd40,                 3'b100},
    {16'd2047,               3'b110}
  };

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%0h exp=%0h", rq, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_addr(input logic [31:0] a);
    addr_wr = 1'b1; addr_val = a; tick(); addr_wr = 1'b0;
  endtask

  task automatic wr_ctl(input logic [15:0] c);
    ctl_wr = 1'b1; ctl_val = c; tick(); ctl_wr = 1'b0;
  endtask

  task automatic pulse_done();
    eng_done = 1'b1; tick(); eng_done = 1'b0;
  endtask

  task automatic clr(input logic [6:0] m);
    clr_wr = 1'b1; clr_mask = m; tick(); clr_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr_wr = 0; ctl_wr = 0; clr_wr = 0; addr_val = '0;
    ctl_val = '0; clr_mask = '0; fifo_lvl = '0; eng_done = 0; eng_col = 0;
    eng_rlim = 0; eng_under = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    chk("R1 status", tx_status, 7'b0000011);
    chk("R1 start", eng_start, 0);

    pulse_done();
    chk("R13 stray done", tx_status, 7'b0000011);

    wr_addr(32'h40);
    wr_ctl(16'd0);
    chk("R2 zero length status", tx_status, 7'b0000011);
    chk("R2 zero length start", eng_start, 0);

    fifo_lvl = 4'd2;
    for (int i = 0; i < 9; i++) begin
      wr_addr(32'h1000 + i);
      wr_ctl(VEC[i][18:3]);
      chk("R3 start", eng_start, 1);
      chk("R2 addr", eng_addr, 32'h1000 + i);
      chk("R2 len", eng_len, {21'b0, VEC[i][13:3]});
      chk("R9 append", eng_append_crc, VEC[i][2]);
      chk("R9 oversize", eng_oversize, VEC[i][1]);
      chk("R9 short", eng_short, VEC[i][0]);
      chk("R7 idle cleared", tx_status[1], 0);
      tick();
      chk("R3 single pulse", eng_start, 0);
      pulse_done();
      chk("R6 comp", tx_status[2], 1);
      chk("R7 idle set", tx_status[1], 1);
      clr(7'b0000100);
      chk("R11 comp cleared", tx_status, 7'b0000011);
    end

    fifo_lvl = 4'd1;
    wr_addr(32'h2000);
    wr_ctl(16'd100);
    chk("R3 gated", eng_start, 0);
    tick();
    chk("R3 gated later", eng_start, 0);
    fifo_lvl = 4'd2;
    #1;
    chk("R3 released", eng_start, 1);
    tick();
    chk("R3 pulse ends", eng_start, 0);

    wr_addr(32'h3000);
    chk("R4 free one slot", tx_status[0], 1);
    wr_ctl(16'h8000 | 16'd200);
    chk("R4 queue full", tx_status[0], 0);
    chk("R8 rd_len held", rd_len, 100);
    chk("R8 rd_nocrc held", rd_nocrc, 0);

    wr_addr(32'h4000);
    chk("R5 overrun on addr", tx_status[3], 1);
    wr_ctl(16'd300);
    chk("R5 still full", tx_status[0], 0);

    pulse_done();
    chk("R6 free again", tx_status[0], 1);
    chk("R6 promoted start", eng_start, 1);
    chk("R5 promoted addr", eng_addr, 32'h3000);
    chk("R5 promoted len", eng_len, 200);
    chk("R8 rd_nocrc new", rd_nocrc, 1);
    chk("R6 comp", tx_status[2], 1);
    chk("R7 idle stays low", tx_status[1], 0);
    tick();

    eng_under = 1'b1; tick(); eng_under = 1'b0;
    chk("R10 und flag", tx_status[4], 1);
    chk("R10 bad crc", eng_bad_crc, 1);
    tick();
    chk("R10 bad crc held", eng_bad_crc, 1);
    pulse_done();
    chk("R10 bad crc drop", eng_bad_crc, 0);
    chk("R10 und sticky", tx_status[4], 1);
    chk("R7 idle after last", tx_status[1], 1);

    eng_col = 1'b1; tick(); eng_col = 1'b0;
    chk("R12 col", tx_status[5], 1);
    eng_rlim = 1'b1; tick(); eng_rlim = 1'b0;
    tick();
    chk("R12 rle sticky", tx_status[6], 1);
    chk("R12 col sticky", tx_status[5], 1);

    eng_col = 1'b1; clr_wr = 1'b1; clr_mask = 7'h7F; tick();
    eng_col = 1'b0; clr_wr = 1'b0;
    chk("R11 set wins, ro bits kept", tx_status, 7'b0100011);
    clr(7'b0100000);
    chk("R11 col cleared", tx_status, 7'b0000011);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule